// File: doc/BRIEF.md
# Segmentable Boundary-Scan Register

This block is the data-register side of a boundary-scan test port for a two-group, 9-bit-per-group bidirectional transceiver. It holds 80 scan cells. Observe-only cells watch the system inputs. Observe-and-drive cells sit on every system output and on the four internal output-enable signals.

The TAP controller supplies three strobes: capture, shift and update. The instruction decoder supplies two controls. A chain select picks the full 80-cell path, a 40-cell path through the observe-only cells, or a 40-cell path through the drive cells. A drive select decides whether the output pins and enables take their values from the update latches (external test) or from the system logic.

Serial data enters at the highest index and moves toward index 0. The serial output is the lowest-indexed cell of the selected path. Cells outside the selected path hold their state.

Top module: `seg_bscan_reg`

## Requirements
- R1: A synchronous active-high `rst` clears every scan stage, every update latch and every registered pin output. After reset, `tdo_o`, `pin_a_o`, `pin_b_o` and `pin_oe_o` are all 0.
- R2: With `chain_sel_i` = 0 the path is 80 cells long. Each `shift_en_i` cycle moves every cell one place toward index 0 and loads `tdi_i` into index 79. `tdo_o` always shows cell 0, so a bit presented on `tdi_i` appears on `tdo_o` after 80 shifts.
- R3: The cell indices are fixed as follows:
  - 79 and 78 are direction and enable inputs of group 1 (`ctl_pins_i[3]`, `[2]`).
  - 77 and 76 are the group-1 A-side and B-side enables (`sys_oe_i[3]`, `[2]`).
  - 75 and 74 are the group-2 direction and enable inputs (`ctl_pins_i[1]`, `[0]`).
  - 73 and 72 are the group-2 A-side and B-side enables (`sys_oe_i[1]`, `[0]`).
  - Below them come nine-cell blocks, from high to low: A1 inputs, A2 inputs, B1 outputs, B2 outputs, B1 inputs, B2 inputs, A1 outputs, A2 outputs. Pin k of a block sits at the block's top index minus k.
  - Group 1 is bits [8:0] of each bus and group 2 is bits [17:9].
- R4: A `capture_en_i` cycle loads every cell of the selected path. Observe-only cells take `a_in_i`, `b_in_i` and `ctl_pins_i`. Drive cells take the system-side values `sys_a_i`, `sys_b_i` and `sys_oe_i`.
- R5: With `chain_sel_i` = 1 only the 40 observe-only cells are in the path, in descending index order. `tdo_o` shows cell 18. Drive cells are not captured, shifted or updated.
- R6: With `chain_sel_i` = 2 only the 40 drive cells are in the path, in descending index order. `tdo_o` shows cell 0. Observe-only cells hold.
- R7: `chain_sel_i` = 3 behaves exactly like 0.
- R8: An `update_en_i` cycle copies each selected drive cell's scan stage into its update latch. The latches hold at all other times, including through capture and shift.
- R9: When `test_drive_i` = 1, `pin_a_o`, `pin_b_o` and `pin_oe_o` follow the update latches, one clock after a latch changes. When `test_drive_i` = 0, they follow `sys_a_i`, `sys_b_i` and `sys_oe_i`, one clock later.
- R10: Under test drive, an enable latch loaded with 1 drives its `pin_oe_o` bit high (active-high enable). The bit order is {A1, B1, A2, B2} from bit 3 down to bit 0.
- R11: When capture and shift are both asserted in one cycle, the capture takes effect and the shift is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_en_i | input | 1 | Capture strobe |
| shift_en_i | input | 1 | Shift strobe |
| update_en_i | input | 1 | Update strobe |
| chain_sel_i | input | 2 | 0/3 full, 1 observe path, 2 drive path |
| test_drive_i | input | 1 | 1: pins from update latches |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| ctl_pins_i | input | 4 | {dir1, en1, dir2, en2} pin values |
| a_in_i | input | 18 | A-side pin inputs |
| b_in_i | input | 18 | B-side pin inputs |
| sys_a_i | input | 18 | System values for A-side outputs |
| sys_b_i | input | 18 | System values for B-side outputs |
| sys_oe_i | input | 4 | System enables {A1, B1, A2, B2} |
| pin_a_o | output | 18 | Driven A-side outputs |
| pin_b_o | output | 18 | Driven B-side outputs |
| pin_oe_o | output | 4 | Driven enables {A1, B1, A2, B2} |

## Verification
Shifting and pin driving happen in the same cycles. While data streams through the drive cells under test drive, the pins must not move until the update strobe fires.

The bench loads a known latch pattern and then shifts a further 80 fresh bits with no update. It compares the pins against its own model, both after the load and after the extra shifting.

A second overlap is a capture and a shift in the same cycle. The bench asserts both strobes together and expects the next serial bit to be the captured cell 0, not a shifted value.

// File: rtl/seg_bsr_pkg.sv
package seg_bsr_pkg;

  typedef enum logic [1:0] {
    CH_FULL     = 2'd0,
    CH_IN       = 2'd1,
    CH_OUT      = 2'd2,
    CH_FULL_ALT = 2'd3
  } chain_sel_e;

  // Data block order from high index to low.
  localparam int G_A1_IN  = 0;
  localparam int G_A2_IN  = 1;
  localparam int G_B1_OUT = 2;
  localparam int G_B2_OUT = 3;
  localparam int G_B1_IN  = 4;
  localparam int G_B2_IN  = 5;
  localparam int G_A1_OUT = 6;
  localparam int G_A2_OUT = 7;

  function automatic int grp_hi(input int w, input int g);
    return 8 * w - 1 - g * w;
  endfunction

  // 1 for a drive (observe/control) cell, 0 for an observe-only cell.
  function automatic bit is_ctl(input int w, input int i);
    int off;
    int g;
    if (i >= 8 * w) begin
      off = i - 8 * w;
      return (off == 5) || (off == 4) || (off == 1) || (off == 0);
    end
    g = (8 * w - 1 - i) / w;
    return (g == G_B1_OUT) || (g == G_B2_OUT) || (g == G_A1_OUT) || (g == G_A2_OUT);
  endfunction

  // Position of cell i inside its own subchain.
  function automatic int rank(input int w, input int i);
    int r;
    r = 0;
    for (int j = 0; j < i; j++) begin
      if (is_ctl(w, j) == is_ctl(w, i)) r++;
    end
    return r;
  endfunction

endpackage

// File: rtl/seg_bsr_obs_cell.sv
module seg_bsr_obs_cell (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic cap_i,
  input  logic shf_i,
  input  logic cap_d_i,
  input  logic shf_d_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)                q_o <= 1'b0;
    else if (sel_i && cap_i) q_o <= cap_d_i;
    else if (sel_i && shf_i) q_o <= shf_d_i;
  end
endmodule

// File: rtl/seg_bsr_ctl_cell.sv
module seg_bsr_ctl_cell (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic cap_i,
  input  logic shf_i,
  input  logic upd_i,
  input  logic cap_d_i,
  input  logic shf_d_i,
  output logic q_o,
  output logic upd_q_o
);
  always_ff @(posedge clk) begin
    if (rst)                q_o <= 1'b0;
    else if (sel_i && cap_i) q_o <= cap_d_i;
    else if (sel_i && shf_i) q_o <= shf_d_i;
  end

  // Update latch: loads only on the update strobe, holds through shifting.
  always_ff @(posedge clk) begin
    if (rst)                upd_q_o <= 1'b0;
    else if (sel_i && upd_i) upd_q_o <= q_o;
  end
endmodule

// File: rtl/seg_bsr_path.sv
module seg_bsr_path #(
  parameter int GRP_W = 9
) (
  input  logic [8*GRP_W+7:0] q_i,
  input  logic               tdi_i,
  input  logic [1:0]         mode_i,
  output logic [8*GRP_W+7:0] src_o,
  output logic [8*GRP_W+7:0] sel_o,
  output logic               tdo_o
);
  import seg_bsr_pkg::*;

  localparam int TOT  = 8 * GRP_W + 8;
  localparam int NSUB = 4 * GRP_W + 4;

  chain_sel_e mode;
  logic full_mode, in_mode, out_mode;
  logic [NSUB-1:0] obs_c, ctl_c;

  assign mode      = chain_sel_e'(mode_i);
  assign full_mode = (mode == CH_FULL) || (mode == CH_FULL_ALT);
  assign in_mode   = (mode == CH_IN);
  assign out_mode  = (mode == CH_OUT);

  for (genvar i = 0; i < TOT; i++) begin : g_link
    localparam bit CTL = is_ctl(GRP_W, i);
    localparam int RNK = rank(GRP_W, i);
    logic full_nxt, sub_nxt;

    // Compact view of each subchain, indexed by rank.
    if (CTL) begin : g_gc
      assign ctl_c[RNK] = q_i[i];
    end else begin : g_go
      assign obs_c[RNK] = q_i[i];
    end

    if (i == TOT - 1) begin : g_ftop
      assign full_nxt = tdi_i;
    end else begin : g_fmid
      assign full_nxt = q_i[i+1];
    end

    if (RNK == NSUB - 1) begin : g_stop
      assign sub_nxt = tdi_i;
    end else if (CTL) begin : g_sctl
      assign sub_nxt = ctl_c[RNK+1];
    end else begin : g_sobs
      assign sub_nxt = obs_c[RNK+1];
    end

    assign src_o[i] = full_mode ? full_nxt : sub_nxt;
    assign sel_o[i] = full_mode | (CTL ? out_mode : in_mode);
  end

  assign tdo_o = full_mode ? q_i[0] : (in_mode ? obs_c[0] : ctl_c[0]);
endmodule

// File: rtl/seg_bscan_reg.sv
module seg_bscan_reg #(
  parameter int GRP_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture_en_i,
  input  logic               shift_en_i,
  input  logic               update_en_i,
  input  logic [1:0]         chain_sel_i,
  input  logic               test_drive_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  input  logic [3:0]         ctl_pins_i,
  input  logic [2*GRP_W-1:0] a_in_i,
  input  logic [2*GRP_W-1:0] b_in_i,
  input  logic [2*GRP_W-1:0] sys_a_i,
  input  logic [2*GRP_W-1:0] sys_b_i,
  input  logic [3:0]         sys_oe_i,
  output logic [2*GRP_W-1:0] pin_a_o,
  output logic [2*GRP_W-1:0] pin_b_o,
  output logic [3:0]         pin_oe_o
);
  import seg_bsr_pkg::*;

  localparam int TOT  = 8 * GRP_W + 8;
  localparam int NSUB = 4 * GRP_W + 4;
  localparam int TOPB = 8 * GRP_W;

  logic [TOT-1:0]     q_v, src_v, sel_v, cap_v;
  logic [NSUB-1:0]    lat_c;
  logic [2*GRP_W-1:0] drv_a, drv_b;
  logic [3:0]         drv_oe;

  // Capture sources for the eight control-group cells.
  assign cap_v[TOPB+7] = ctl_pins_i[3];
  assign cap_v[TOPB+6] = ctl_pins_i[2];
  assign cap_v[TOPB+5] = sys_oe_i[3];
  assign cap_v[TOPB+4] = sys_oe_i[2];
  assign cap_v[TOPB+3] = ctl_pins_i[1];
  assign cap_v[TOPB+2] = ctl_pins_i[0];
  assign cap_v[TOPB+1] = sys_oe_i[1];
  assign cap_v[TOPB]   = sys_oe_i[0];

  assign drv_oe = {lat_c[rank(GRP_W, TOPB+5)], lat_c[rank(GRP_W, TOPB+4)],
                   lat_c[rank(GRP_W, TOPB+1)], lat_c[rank(GRP_W, TOPB)]};

  // Capture sources and latch fan-out for the data blocks.
  for (genvar g = 0; g < 8; g++) begin : g_grp
    for (genvar k = 0; k < GRP_W; k++) begin : g_pin
      localparam int IDX = grp_hi(GRP_W, g) - k;
      localparam int RNK = rank(GRP_W, IDX);
      if (g == G_A1_IN) begin : g_a1i
        assign cap_v[IDX] = a_in_i[k];
      end else if (g == G_A2_IN) begin : g_a2i
        assign cap_v[IDX] = a_in_i[GRP_W+k];
      end else if (g == G_B1_IN) begin : g_b1i
        assign cap_v[IDX] = b_in_i[k];
      end else if (g == G_B2_IN) begin : g_b2i
        assign cap_v[IDX] = b_in_i[GRP_W+k];
      end else if (g == G_B1_OUT) begin : g_b1o
        assign cap_v[IDX] = sys_b_i[k];
        assign drv_b[k]   = lat_c[RNK];
      end else if (g == G_B2_OUT) begin : g_b2o
        assign cap_v[IDX]       = sys_b_i[GRP_W+k];
        assign drv_b[GRP_W+k]   = lat_c[RNK];
      end else if (g == G_A1_OUT) begin : g_a1o
        assign cap_v[IDX] = sys_a_i[k];
        assign drv_a[k]   = lat_c[RNK];
      end else begin : g_a2o
        assign cap_v[IDX]       = sys_a_i[GRP_W+k];
        assign drv_a[GRP_W+k]   = lat_c[RNK];
      end
    end
  end

  seg_bsr_path #(.GRP_W(GRP_W)) path_i (
    .q_i    (q_v),
    .tdi_i  (tdi_i),
    .mode_i (chain_sel_i),
    .src_o  (src_v),
    .sel_o  (sel_v),
    .tdo_o  (tdo_o)
  );

  for (genvar i = 0; i < TOT; i++) begin : g_cell
    localparam bit CTL = is_ctl(GRP_W, i);
    localparam int RNK = rank(GRP_W, i);
    if (CTL) begin : g_ctl
      seg_bsr_ctl_cell cell_i (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (sel_v[i]),
        .cap_i   (capture_en_i),
        .shf_i   (shift_en_i),
        .upd_i   (update_en_i),
        .cap_d_i (cap_v[i]),
        .shf_d_i (src_v[i]),
        .q_o     (q_v[i]),
        .upd_q_o (lat_c[RNK])
      );
    end else begin : g_obs
      seg_bsr_obs_cell cell_i (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (sel_v[i]),
        .cap_i   (capture_en_i),
        .shf_i   (shift_en_i),
        .cap_d_i (cap_v[i]),
        .shf_d_i (src_v[i]),
        .q_o     (q_v[i])
      );
    end
  end

  // Registered pin stage: test latches or system path.
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_a_o  <= '0;
      pin_b_o  <= '0;
      pin_oe_o <= '0;
    end else if (test_drive_i) begin
      pin_a_o  <= drv_a;
      pin_b_o  <= drv_b;
      pin_oe_o <= drv_oe;
    end else begin
      pin_a_o  <= sys_a_i;
      pin_b_o  <= sys_b_i;
      pin_oe_o <= sys_oe_i;
    end
  end
endmodule

// File: rtl/seg_bscan_reg_chk.sv
module seg_bscan_reg_chk #(
  parameter int GRP_W = 9
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   capture_en_i,
  input logic                   update_en_i,
  input logic [1:0]             chain_sel_i,
  input logic                   test_drive_i,
  input logic [2*GRP_W-1:0]     sys_a_i,
  input logic [3:0]             sys_oe_i,
  input logic                   tdo_o,
  input logic [3:0]             pin_oe_o,
  input logic [8*GRP_W+7:0]     q_v,
  input logic [4*GRP_W+3:0]     lat_c
);
  import seg_bsr_pkg::*;

  localparam int TOT = 8 * GRP_W + 8;

  function automatic logic [TOT-1:0] ctl_mask();
    logic [TOT-1:0] m;
    for (int i = 0; i < TOT; i++) m[i] = is_ctl(GRP_W, i);
    return m;
  endfunction

  localparam logic [TOT-1:0] CTL_MASK = ctl_mask();

  // R8: latches move only on an update strobe
  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !update_en_i |=> $stable(lat_c));

  // R9: system path reaches the enables one clock later
  assert_sys_path_R9: assert property (@(posedge clk) disable iff (rst)
    !test_drive_i |=> (pin_oe_o == $past(sys_oe_i)));

  // R5: observe path leaves every drive stage untouched
  assert_in_isolation_R5: assert property (@(posedge clk) disable iff (rst)
    (chain_sel_i == CH_IN) |=> $stable(q_v & CTL_MASK));

  // R6: drive path leaves every observe stage untouched
  assert_out_isolation_R6: assert property (@(posedge clk) disable iff (rst)
    (chain_sel_i == CH_OUT) |=> $stable(q_v & ~CTL_MASK));

  // R4: a full capture puts the last A2 system output on the serial out
  assert_capture_tail_R4: assert property (@(posedge clk) disable iff (rst)
    (capture_en_i && chain_sel_i == CH_FULL) |=> (tdo_o == $past(sys_a_i[2*GRP_W-1])));
endmodule

bind seg_bscan_reg seg_bscan_reg_chk #(.GRP_W(GRP_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .capture_en_i (capture_en_i),
  .update_en_i  (update_en_i),
  .chain_sel_i  (chain_sel_i),
  .test_drive_i (test_drive_i),
  .sys_a_i      (sys_a_i),
  .sys_oe_i     (sys_oe_i),
  .tdo_o        (tdo_o),
  .pin_oe_o     (pin_oe_o),
  .q_v          (q_v),
  .lat_c        (lat_c)
);

// File: tb/seg_bscan_reg_tb_top.sv
module seg_bscan_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 9;
  localparam int TOT = 8 * W + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic capture_en = 0, shift_en = 0, update_en = 0, test_drive = 1, tdi = 0;
  logic [1:0] chain_sel = 0;
  logic [3:0] ctl_pins = 0, sys_oe = 0;
  logic [2*W-1:0] a_in = 0, b_in = 0, sys_a = 0, sys_b = 0;
  logic tdo;
  logic [2*W-1:0] pin_a, pin_b;
  logic [3:0] pin_oe;

  bit ref_q [TOT];
  bit ref_l [TOT];
  bit exp_q [$];
  string tag_q [$];
  int checks = 0, fails = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_bscan_reg #(.GRP_W(W)) dut_i (
    .clk(clk), .rst(rst), .capture_en_i(capture_en), .shift_en_i(shift_en),
    .update_en_i(update_en), .chain_sel_i(chain_sel), .test_drive_i(test_drive),
    .tdi_i(tdi), .tdo_o(tdo), .ctl_pins_i(ctl_pins), .a_in_i(a_in), .b_in_i(b_in),
    .sys_a_i(sys_a), .sys_b_i(sys_b), .sys_oe_i(sys_oe),
    .pin_a_o(pin_a), .pin_b_o(pin_b), .pin_oe_o(pin_oe)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ghi(int g);
    return 8 * W - 1 - g * W;
  endfunction

  // R3 cell kinds: observe-only on inputs
  function automatic bit is_obs(int i);
    int off, g;
    if (i >= 8 * W) begin
      off = i - 8 * W;
      return off == 7 || off == 6 || off == 3 || off == 2;
    end
    g = (8 * W - 1 - i) / W;
    return g == 0 || g == 1 || g == 4 || g == 5;
  endfunction

  function automatic bit in_sel(int i, int m);
    if (m == 1) return is_obs(i);
    if (m == 2) return !is_obs(i);
    return 1'b1;
  endfunction

  function automatic bit cap_val(int i);
    int off, g, k;
    if (i >= 8 * W) begin
      off = i - 8 * W;
      case (off)
        7: return ctl_pins[3];
        6: return ctl_pins[2];
        5: return sys_oe[3];
        4: return sys_oe[2];
        3: return ctl_pins[1];
        2: return ctl_pins[0];
        1: return sys_oe[1];
        default: return sys_oe[0];
      endcase
    end
    g = (8 * W - 1 - i) / W;
    k = ghi(g) - i;
    case (g)
      0: return a_in[k];
      1: return a_in[W+k];
      2: return sys_b[k];
      3: return sys_b[W+k];
      4: return b_in[k];
      5: return b_in[W+k];
      6: return sys_a[k];
      default: return sys_a[W+k];
    endcase
  endfunction

  // Scoreboard monitor: compares serial out in every shift-only cycle.
  always @(negedge clk) begin
    if (!rst && shift_en && !capture_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 empty scoreboard", 64'(tdo), 0);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(tdo === e, t, 64'(tdo), 64'(e));
      end
    end
  end

  // Tasks start and end just after a rising edge.
  task automatic capture(int m);
    chain_sel = 2'(m);
    capture_en = 1;
    for (int i = 0; i < TOT; i++) if (in_sel(i, m)) ref_q[i] = cap_val(i);
    @(posedge clk); #1;
    capture_en = 0;
  endtask

  // fill: 0 pseudo-random, 1 ones, 2 zeros
  task automatic shift_n(int m, int n, int fill, string tag);
    chain_sel = 2'(m);
    for (int j = 0; j < n; j++) begin
      bit prev, t;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      prev = (fill == 0) ? lfsr[0] : (fill == 1);
      tdi = prev;
      for (int i = TOT - 1; i >= 0; i--) begin
        if (in_sel(i, m)) begin
          t = ref_q[i];
          ref_q[i] = prev;
          prev = t;
        end
      end
      exp_q.push_back(prev);
      tag_q.push_back(tag);
      shift_en = 1;
      @(posedge clk); #1;
    end
    shift_en = 0;
  endtask

  task automatic update(int m);
    chain_sel = 2'(m);
    update_en = 1;
    for (int i = 0; i < TOT; i++) if (in_sel(i, m) && !is_obs(i)) ref_l[i] = ref_q[i];
    @(posedge clk); #1;
    update_en = 0;
  endtask

  task automatic check_outs(string tag);
    logic [2*W-1:0] ea, eb;
    logic [3:0] eo;
    for (int k = 0; k < W; k++) begin
      ea[k]   = test_drive ? ref_l[ghi(6)-k] : sys_a[k];
      ea[W+k] = test_drive ? ref_l[ghi(7)-k] : sys_a[W+k];
      eb[k]   = test_drive ? ref_l[ghi(2)-k] : sys_b[k];
      eb[W+k] = test_drive ? ref_l[ghi(3)-k] : sys_b[W+k];
    end
    eo = test_drive ? {ref_l[8*W+5], ref_l[8*W+4], ref_l[8*W+1], ref_l[8*W]} : sys_oe;
    chk(pin_a === ea, {tag, " pin_a"}, 64'(pin_a), 64'(ea));
    chk(pin_b === eb, {tag, " pin_b"}, 64'(pin_b), 64'(eb));
    chk(pin_oe === eo, {tag, " pin_oe"}, 64'(pin_oe), 64'(eo));
  endtask

  task automatic set_inputs(logic [17:0] s);
    a_in = s; b_in = ~s ^ 18'h0F0F0; sys_a = {s[8:0], s[17:9]};
    sys_b = s ^ 18'h15A5A; ctl_pins = s[3:0] ^ 4'h9; sys_oe = s[7:4];
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset state, before any edge out of reset
    chk(tdo === 1'b0, "R1 tdo", 64'(tdo), 0);
    chk(pin_a === '0 && pin_b === '0, "R1 pins", 64'(pin_a), 0);
    chk(pin_oe === 4'h0, "R1 enables", 64'(pin_oe), 0);
    set_inputs(18'h2B3C5);
    @(posedge clk); #1;
    check_outs("R1 latches cleared");

    // R2 R3 R4: full capture, 80 captured bits then 80 fresh bits
    capture(0);
    shift_n(0, 160, 0, "R2 R3 R4 full chain");

    // R9: system path
    test_drive = 0;
    @(posedge clk); #1;
    check_outs("R9 system path");
    set_inputs(18'h1C0F3);
    @(posedge clk); #1;
    check_outs("R9 system path change");

    // R8 R10: load all ones, update, pins from latches
    test_drive = 1;
    shift_n(0, 80, 1, "R8 load ones");
    update(0);
    @(posedge clk); #1;
    check_outs("R10 enables high");
    chk(pin_oe === 4'hF, "R10 enable bits", 64'(pin_oe), 64'hF);
    shift_n(0, 80, 2, "R8 load zeros");
    update(0);
    @(posedge clk); #1;
    check_outs("R10 enables low");
    shift_n(0, 80, 0, "R8 random");
    update(0);
    @(posedge clk); #1;
    check_outs("R8 random latch");
    // R8: shifting without update leaves pins alone
    shift_n(0, 80, 0, "R8 shift no update");
    @(posedge clk); #1;
    check_outs("R8 hold through shift");

    // R5: observe path, drive cells untouched even by update
    set_inputs(18'h35A96);
    capture(1);
    shift_n(1, 50, 0, "R5 observe path");
    update(1);
    @(posedge clk); #1;
    check_outs("R5 update ignored");
    shift_n(0, 80, 0, "R5 drive stages held");

    // R6: drive path, observe cells held
    set_inputs(18'h0E71B);
    capture(2);
    shift_n(2, 45, 0, "R6 drive path");
    shift_n(0, 80, 0, "R6 observe stages held");
    shift_n(2, 40, 0, "R6 drive load");
    update(2);
    @(posedge clk); #1;
    check_outs("R6 drive path update");

    // R7: code 3 is the full chain
    set_inputs(18'h3F00C);
    capture(3);
    shift_n(3, 90, 0, "R7 alt full chain");

    // R11: capture wins over shift in the same cycle
    set_inputs(18'h12345);
    chain_sel = 0;
    capture_en = 1;
    shift_en = 1;
    for (int i = 0; i < TOT; i++) ref_q[i] = cap_val(i);
    @(posedge clk); #1;
    capture_en = 0;
    shift_en = 0;
    shift_n(0, 12, 0, "R11 capture priority");

    @(posedge clk); #1;
    chk(exp_q.size() == 0, "R2 scoreboard drained", 64'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule